// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block keeps track of the operating mode of a small microcontroller and turns that mode into clock enables. The CPU reaches RUN when the synchronous reset is released. From RUN it can stop in HALT, where only the CPU clock is gated, or drop into SLEEP, where the clock sources are also stopped. Four per-source keep bits can hold individual sources running through SLEEP so that the peripherals fed by them continue to work. A wake event returns HALT to RUN at once. From SLEEP it passes through a stabilisation phase of programmable length before the CPU clock is released.

A debug interrupt pulls the block into DEBUG from any active mode. A debug-return strobe puts it back into the mode it left, including a stabilisation phase that was cut short. The block also samples which clock source drives the system clock while in RUN and reports it, so RUN, HALT and the other modes can be labelled by source. The block has no reset or memory-clear output, so entering or leaving SLEEP never disturbs RAM contents.

Top module: `pwrmode_ctrl`

## Requirements
- R1: Mode codes are 0 reset, 1 RUN, 2 HALT, 3 SLEEP, 4 WAKE (stabilising), 5 DEBUG. On the first clock edge with `rst` low after reset, the mode becomes RUN. RUN has `cpu_clk_en`=1 and `src_en`=4'b1111.
- R2: `halt_req` in RUN gives HALT on the next edge. HALT has `cpu_clk_en`=0 and `src_en`=4'b1111.
- R3: `sleep_req` in RUN gives SLEEP on the next edge, and SLEEP has `cpu_clk_en`=0.
- R4: In SLEEP, `src_en[i]` equals the inverse of `slp_stop[i]` and follows it combinationally. Bit 0 is the internal oscillator, bit 1 the low-speed crystal, bit 2 the high-speed crystal and bit 3 the external clock.
- R5: `dbg_irq` in RUN, HALT, SLEEP or WAKE gives DEBUG on the next edge and takes priority over every other request. DEBUG has `cpu_clk_en`=1 and `src_en`=4'b1111. `dbg_irq` in DEBUG has no effect.
- R6: `sys_src` takes the value of `sysclk_sel` on every edge at which the mode is RUN, and holds its value in all other modes.
- R7: `wake` in HALT gives RUN on the next edge.
- R8: `wake` in SLEEP gives WAKE and loads `stab_cycles`=N. WAKE lasts exactly N+1 cycles with `cpu_clk_en`=0 and `src_en`=4'b1111, and then the mode becomes RUN.
- R9: `halt_req` and `sleep_req` in the same RUN cycle give SLEEP.
- R10: `halt_req` and `sleep_req` outside RUN, and `wake` in RUN, DEBUG or reset, have no effect on the mode.
- R11: `dbg_ret` in DEBUG returns to the mode held when DEBUG was entered. A WAKE count that DEBUG interrupted resumes from where it stopped. `dbg_ret` outside DEBUG is ignored.
- R12: `rst` high in any mode gives the reset state on the next edge: mode 0, `cpu_clk_en`=0, `src_en`=4'b0001, `sys_src`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset request |
| halt_req | input | 1 | Halt request from the CPU |
| sleep_req | input | 1 | Sleep request from the CPU |
| dbg_irq | input | 1 | Debug interrupt |
| dbg_ret | input | 1 | Debug return strobe |
| wake | input | 1 | Enabled interrupt that wakes the CPU |
| slp_stop | input | 4 | Per-source stop-in-sleep bits (0 keeps the source running) |
| sysclk_sel | input | 2 | Source currently selected as system clock |
| stab_cycles | input | 8 | Stabilisation length after SLEEP |
| mode | output | 3 | Current operating mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| src_en | output | 4 | Clock source enables |
| sys_src | output | 2 | Reported system clock source |

## Verification
On every cycle the assertions check the clock enables for each mode, the RUN and sleep priority, the mode that follows a debug interrupt, and that a held mode ignores stray requests. They also check that the reported source stays frozen outside RUN. Only the directed scenarios can show three things: that a return from DEBUG restores the exact mode that was interrupted, that an interrupted stabilisation count resumes rather than restarts, and that WAKE lasts exactly N+1 cycles for the programmed N.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int N_SRC   = 4;
    localparam int SEL_W   = $clog2(N_SRC);
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_RESET = 3'd0,
        MODE_RUN   = 3'd1,
        MODE_HALT  = 3'd2,
        MODE_SLEEP = 3'd3,
        MODE_WAKE  = 3'd4,
        MODE_DEBUG = 3'd5
    } mode_e;

    typedef struct packed {
        logic halt;
        logic sleep;
        logic dbg_in;
        logic dbg_out;
        logic wake;
    } req_t;

    // Only the internal oscillator (index 0) runs out of reset.
    function automatic logic src_reset_value(input int idx);
        return (idx == 0);
    endfunction

    function automatic logic cpu_runs(input mode_e m);
        return (m == MODE_RUN) || (m == MODE_DEBUG);
    endfunction

    function automatic logic debug_entry_ok(input mode_e m);
        return (m == MODE_RUN) || (m == MODE_HALT) ||
               (m == MODE_SLEEP) || (m == MODE_WAKE);
    endfunction

endpackage

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
    import pwrmode_pkg::*;
#(
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [STAB_W-1:0] stab_cycles,
    output mode_e             state
);

    mode_e             state_q;
    mode_e             resume_q;
    logic [STAB_W-1:0] stab_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= MODE_RESET;
            resume_q   <= MODE_RUN;
            stab_cnt_q <= '0;
        end else if (req.dbg_in && debug_entry_ok(state_q)) begin
            resume_q <= state_q;
            state_q  <= MODE_DEBUG;
        end else begin
            unique case (state_q)
                MODE_RESET: state_q <= MODE_RUN;
                MODE_RUN: begin
                    if (req.sleep)     state_q <= MODE_SLEEP;
                    else if (req.halt) state_q <= MODE_HALT;
                end
                MODE_HALT: begin
                    if (req.wake) state_q <= MODE_RUN;
                end
                MODE_SLEEP: begin
                    if (req.wake) begin
                        state_q    <= MODE_WAKE;
                        stab_cnt_q <= stab_cycles;
                    end
                end
                MODE_WAKE: begin
                    if (stab_cnt_q == '0) state_q <= MODE_RUN;
                    else                  stab_cnt_q <= stab_cnt_q - 1'b1;
                end
                MODE_DEBUG: begin
                    if (req.dbg_out) state_q <= resume_q;
                end
                default: state_q <= MODE_RESET;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pwrmode_clkgate.sv
module pwrmode_clkgate
    import pwrmode_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  mode_e         state,
    input  logic [NS-1:0] slp_stop,
    output logic          cpu_clk_en,
    output logic [NS-1:0] src_en
);

    assign cpu_clk_en = cpu_runs(state);

    for (genvar g = 0; g < NS; g++) begin : g_src
        always_comb begin
            unique case (state)
                MODE_RESET: src_en[g] = src_reset_value(g);
                MODE_SLEEP: src_en[g] = ~slp_stop[g];
                default:    src_en[g] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pwrmode_srcsel.sv
module pwrmode_srcsel
    import pwrmode_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         state,
    input  logic [SW-1:0] sysclk_sel,
    output logic [SW-1:0] sys_src
);

    logic [SW-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst)                    src_q <= '0;
        else if (state == MODE_RUN) src_q <= sysclk_sel;
    end

    assign sys_src = src_q;

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int STAB_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req,
    input  logic               sleep_req,
    input  logic               dbg_irq,
    input  logic               dbg_ret,
    input  logic               wake,
    input  logic [N_SRC-1:0]   slp_stop,
    input  logic [SEL_W-1:0]   sysclk_sel,
    input  logic [STAB_W-1:0]  stab_cycles,
    output logic [MODE_W-1:0]  mode,
    output logic               cpu_clk_en,
    output logic [N_SRC-1:0]   src_en,
    output logic [SEL_W-1:0]   sys_src
);

    req_t  req;
    mode_e state;

    assign req = '{halt: halt_req, sleep: sleep_req, dbg_in: dbg_irq,
                   dbg_out: dbg_ret, wake: wake};

    pwrmode_fsm #(.STAB_W(STAB_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .stab_cycles (stab_cycles),
        .state       (state)
    );

    pwrmode_clkgate #(.NS(N_SRC)) u_gate (
        .state      (state),
        .slp_stop   (slp_stop),
        .cpu_clk_en (cpu_clk_en),
        .src_en     (src_en)
    );

    pwrmode_srcsel #(.SW(SEL_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .sysclk_sel (sysclk_sel),
        .sys_src    (sys_src)
    );

    assign mode = state;

endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk
    import pwrmode_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              halt_req,
    input logic              sleep_req,
    input logic              dbg_irq,
    input logic              wake,
    input logic [N_SRC-1:0]  slp_stop,
    input logic [MODE_W-1:0] mode,
    input logic              cpu_clk_en,
    input logic [N_SRC-1:0]  src_en,
    input logic [SEL_W-1:0]  sys_src
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mode == MODE_RESET) && !cpu_clk_en && (src_en == 4'b0001)); // R12

    AST_RELEASE_RUN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RESET) |=> (mode == MODE_RUN)); // R1

    AST_HALT_GATE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HALT) |-> !cpu_clk_en && (src_en == 4'b1111)); // R2

    AST_SLEEP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP) |-> !cpu_clk_en && (src_en == ~slp_stop)); // R4

    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WAKE) |-> !cpu_clk_en && (src_en == 4'b1111)); // R8

    AST_DEBUG_ENTRY: assert property (@(posedge clk) disable iff (rst)
        dbg_irq && (mode inside {MODE_RUN, MODE_HALT, MODE_SLEEP, MODE_WAKE})
        |=> (mode == MODE_DEBUG)); // R5

    AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN) && halt_req && sleep_req && !dbg_irq
        |=> (mode == MODE_SLEEP)); // R9

    AST_HALT_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HALT) && !wake && !dbg_irq |=> (mode == MODE_HALT)); // R10

    AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_RUN) |=> $stable(sys_src)); // R6

endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .sleep_req  (sleep_req),
    .dbg_irq    (dbg_irq),
    .wake       (wake),
    .slp_stop   (slp_stop),
    .mode       (mode),
    .cpu_clk_en (cpu_clk_en),
    .src_en     (src_en),
    .sys_src    (sys_src)
);

// File: tb/pwrmode_ctrl_bench.sv
`timescale 1ns/1ps
module pwrmode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_req = 0, sleep_req = 0, dbg_irq = 0, dbg_ret = 0, wake = 0;
    logic [3:0] slp_stop = 4'b1111;
    logic [1:0] sysclk_sel = 2'd0;
    logic [7:0] stab_cycles = 8'd0;
    logic [2:0] mode;
    logic       cpu_clk_en;
    logic [3:0] src_en;
    logic [1:0] sys_src;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    localparam logic [2:0] M_RST = 3'd0, M_RUN = 3'd1, M_HALT = 3'd2,
                           M_SLP = 3'd3, M_WAKE = 3'd4, M_DBG = 3'd5;

    always #4 clk = ~clk;

    pwrmode_ctrl u_pwrmode_ctrl (
        .clk(clk), .rst(rst), .halt_req(halt_req), .sleep_req(sleep_req),
        .dbg_irq(dbg_irq), .dbg_ret(dbg_ret), .wake(wake), .slp_stop(slp_stop),
        .sysclk_sel(sysclk_sel), .stab_cycles(stab_cycles), .mode(mode),
        .cpu_clk_en(cpu_clk_en), .src_en(src_en), .sys_src(sys_src)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_reqs();
        halt_req = 0; sleep_req = 0; dbg_irq = 0; dbg_ret = 0; wake = 0;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk_mode(input string req, input logic [2:0] m,
                            input logic cpu, input logic [3:0] src);
        chk({req, " mode"}, mode, m);
        chk({req, " cpu_clk_en"}, cpu_clk_en, cpu);
        chk({req, " src_en"}, src_en, src);
    endtask

    task automatic t_reset_release();
        rst = 1; clear_reqs(); tick(); tick();
        chk_mode("R12", M_RST, 0, 4'b0001);
        chk("R12 sys_src", sys_src, 0);
        rst = 0; tick();
        chk_mode("R1", M_RUN, 1, 4'b1111);
    endtask

    task automatic t_halt();
        sysclk_sel = 2'd2; tick();
        chk("R6 capture", sys_src, 2);
        halt_req = 1; tick(); halt_req = 0;
        chk_mode("R2", M_HALT, 0, 4'b1111);
        sleep_req = 1; sysclk_sel = 2'd3; tick(); sleep_req = 0;
        chk("R10 sleep in HALT", mode, M_HALT);
        chk("R6 hold", sys_src, 2);
        wake = 1; tick(); wake = 0;
        chk_mode("R7", M_RUN, 1, 4'b1111);
        wake = 1; tick(); wake = 0;
        chk("R10 wake in RUN", mode, M_RUN);
        chk("R6 recapture", sys_src, 3);
    endtask

    task automatic t_sleep_wake();
        slp_stop = 4'b1010; stab_cycles = 8'd3;
        sleep_req = 1; tick(); sleep_req = 0;
        chk_mode("R3", M_SLP, 0, 4'b0101);
        slp_stop = 4'b0110; #1;
        chk("R4 keep follow", src_en, 4'b1001);
        tick();
        chk("R4 still SLEEP", mode, M_SLP);
        wake = 1; tick(); wake = 0;
        for (int i = 0; i < 4; i++) begin
            chk_mode("R8 stabilising", M_WAKE, 0, 4'b1111);
            tick();
        end
        chk_mode("R8 released", M_RUN, 1, 4'b1111);
    endtask

    task automatic t_priority();
        slp_stop = 4'b1111; stab_cycles = 8'd0;
        halt_req = 1; sleep_req = 1; tick(); clear_reqs();
        chk_mode("R9", M_SLP, 0, 4'b0000);
        wake = 1; tick(); wake = 0;
        chk("R8 N=0 one cycle", mode, M_WAKE);
        tick();
        chk("R8 N=0 run", mode, M_RUN);
    endtask

    task automatic t_debug();
        dbg_ret = 1; tick(); dbg_ret = 0;
        chk("R11 ret outside DEBUG", mode, M_RUN);
        halt_req = 1; tick(); halt_req = 0;
        dbg_irq = 1; wake = 1; tick(); clear_reqs();
        chk_mode("R5 from HALT", M_DBG, 1, 4'b1111);
        dbg_irq = 1; halt_req = 1; tick(); clear_reqs();
        chk("R5 irq in DEBUG", mode, M_DBG);
        dbg_ret = 1; tick(); dbg_ret = 0;
        chk("R11 back to HALT", mode, M_HALT);
        wake = 1; tick(); wake = 0;
        slp_stop = 4'b1101;
        sleep_req = 1; tick(); sleep_req = 0;
        dbg_irq = 1; tick(); dbg_irq = 0;
        chk("R5 from SLEEP", mode, M_DBG);
        dbg_ret = 1; tick(); dbg_ret = 0;
        chk_mode("R11 back to SLEEP", M_SLP, 0, 4'b0010);
        stab_cycles = 8'd2;
        wake = 1; tick(); wake = 0;
        tick();
        dbg_irq = 1; tick(); dbg_irq = 0;
        chk("R5 from WAKE", mode, M_DBG);
        dbg_ret = 1; tick(); dbg_ret = 0;
        chk("R11 back to WAKE", mode, M_WAKE);
        tick();
        chk("R11 count resumes", mode, M_WAKE);
        tick();
        chk("R11 resumed release", mode, M_RUN);
    endtask

    task automatic t_reset_any();
        slp_stop = 4'b0000;
        sleep_req = 1; tick(); sleep_req = 0;
        chk("R3 enter", mode, M_SLP);
        rst = 1; tick();
        chk_mode("R12 from SLEEP", M_RST, 0, 4'b0001);
        chk("R12 sys_src", sys_src, 0);
        rst = 0; tick();
        chk("R1 again", mode, M_RUN);
        dbg_irq = 1; tick(); dbg_irq = 0;
        rst = 1; tick();
        chk_mode("R12 from DEBUG", M_RST, 0, 4'b0001);
        rst = 0; tick();
    endtask

    initial begin
        t_reset_release();
        t_halt();
        t_sleep_wake();
        t_priority();
        t_debug();
        t_reset_any();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule